// File: doc/BRIEF.md
# Switch Control Register Bank with Split 64-bit Writes

This block is the register file that a host uses to steer a multi-port switch. A simple request bus carries reads and writes of 4 or 8 bytes, little-endian, with one request per cycle and the read answer registered one cycle later. The bank holds a 32-bit scratch register and a 64-bit scratch register, both of which read back doubled. It also holds a 64-bit test DMA address, a 32-bit test DMA size, a read-only port count and a read-only 64-bit switch identifier. A link-status bitmap is built from per-port link inputs. A port-enable bitmap drives the per-port enable outputs. A write-only control word carries a reset bit.

A host that can only issue 32-bit accesses can still load any writable 64-bit register. It writes the low word first, which only parks the value in one staging register shared by every 64-bit register. It then writes the high word, which commits both halves together and empties the staging register. A single 8-byte write commits the whole value at once. Both port bitmaps put port i at bit i+1. Bit 0 is never used.

Top module: `swreg_bank`

## Requirements
- R1: After reset, every stored register, the staging register and the port-enable outputs are zero, and no read response is flagged.
- R2: A read request is answered on the cycle after it is accepted, with `rdValid` high for that cycle. A 4-byte read returns its word in bits 31:0 with bits 63:32 zero.
- R3: A 4-byte write to the low word of the 64-bit scratch (0x18), DMA address (0x20) or port-enable (0x48) register only loads the shared staging register. A 4-byte write to the matching high word (0x1C, 0x24, 0x4C) commits {written word, staged word} to that register and clears the staging register, whichever register the staged word was aimed at.
- R4: An 8-byte write to 0x18, 0x20 or 0x48 commits all 64 bits in one access and leaves the staging register untouched.
- R5: Reading the 32-bit scratch register (0x10) returns the stored value times two, truncated to 32 bits. Reading the 64-bit scratch register returns the stored value times two, truncated to 64 bits; its 4-byte halves at 0x18 and 0x1C come from that doubled value.
- R6: 4-byte reads of 0x00, 0x04, 0x08 and 0x0C return 0xDEADBABE. 8-byte reads of 0x00 and 0x08 return 0xDEADBABEDEADBABE.
- R7: In the link-status bitmap (0x40) and the port-enable bitmap (0x48), port i sits at bit i+1. Bit 0 and bits above the port count read zero and are dropped on write. Output `portEnable[i]` follows bit i+1 of the enable bitmap.
- R8: A 4-byte write to the control word (0x30) with bit 0 set clears the scratch registers, the DMA address and size, the staging register and every port enable, and raises `ctrlResetPulse` for exactly the following cycle. With bit 0 clear, the write changes nothing.
- R9: The port count (0x38) reads the configured port count, capped at the maximum the bank supports.
- R10: Reads of unimplemented addresses return zero and writes to them change nothing. This covers misaligned addresses and 8-byte accesses to 32-bit-only or high-word addresses.
- R11: A request whose size is neither 4 nor 8 bytes is ignored when it is a write and reads back all ones.
- R12: The switch identifier (0x50, high word 0x54) is a fixed parameter and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 4 | Access size in bytes |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| rdValid | output | 1 | Read answer valid |
| rdData | output | 64 | Read answer |
| linkUp | input | MAX_PORTS | Per-port link state, index = port |
| portEnable | output | MAX_PORTS | Per-port enable, index = port |
| ctrlResetPulse | output | 1 | One-cycle pulse after a control reset |

## Verification
The embedded assertions check several rules on every cycle. A write of an illegal size never raises a write strobe. A high-word commit always leaves the staging register empty. The enable outputs hold unless an enable write or a control reset occurs. The reset pulse always coincides with cleared registers. Every accepted read is answered on the next cycle. The bench scenarios are needed for the value-level behaviour: doubling on readback, the sharing of one staged word across different registers, the bit offset in both bitmaps, the dummy words and the all-ones answer to odd sizes. These are compared against a reference model driven by a seeded random mix of accesses.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

  localparam logic [7:0] A_DUMMY0  = 8'h00;
  localparam logic [7:0] A_DUMMY1  = 8'h04;
  localparam logic [7:0] A_DUMMY2  = 8'h08;
  localparam logic [7:0] A_DUMMY3  = 8'h0C;
  localparam logic [7:0] A_SCR32   = 8'h10;
  localparam logic [7:0] A_SCR64   = 8'h18;
  localparam logic [7:0] A_SCR64H  = 8'h1C;
  localparam logic [7:0] A_DMAAD   = 8'h20;
  localparam logic [7:0] A_DMAADH  = 8'h24;
  localparam logic [7:0] A_DMASZ   = 8'h28;
  localparam logic [7:0] A_CTRL    = 8'h30;
  localparam logic [7:0] A_COUNT   = 8'h38;
  localparam logic [7:0] A_LINK    = 8'h40;
  localparam logic [7:0] A_LINKH   = 8'h44;
  localparam logic [7:0] A_ENAB    = 8'h48;
  localparam logic [7:0] A_ENABH   = 8'h4C;
  localparam logic [7:0] A_SWID    = 8'h50;
  localparam logic [7:0] A_SWIDH   = 8'h54;

  localparam logic [63:0] DUMMY_WORD = 64'hDEADBABE_DEADBABE;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DUMMY, SEL_SCR32, SEL_SCR64, SEL_DMAAD,
    SEL_DMASZ, SEL_COUNT, SEL_LINK, SEL_ENAB, SEL_SWID
  } rdSel_e;

  typedef struct packed {
    logic   wrScr32;
    logic   wrScr64;
    logic   wrDmaAddr;
    logic   wrDmaSize;
    logic   wrEnable;
    logic   wrStage;
    logic   commitHi;
    logic   doReset;
    logic   rdEn;
    logic   rdOnes;
    logic   rdWide;
    logic   rdHi;
    rdSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [3:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              resetBit,
  output bankStrobe_t       strobe
);

  logic ok4, ok8, badSize;
  assign ok4     = (reqSize == 4'd4);
  assign ok8     = (reqSize == 4'd8);
  assign badSize = !ok4 && !ok8;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] c);
    return a == ADDR_W'(c);
  endfunction

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = SEL_NONE;
    strobe.rdEn   = reqValid && !reqWrite;
    strobe.rdOnes = badSize;
    strobe.rdWide = ok8;
    strobe.rdHi   = reqAddr[2];
    if (reqValid && reqWrite && ok4) begin
      if (at(reqAddr, A_SCR32))  strobe.wrScr32 = 1'b1;
      if (at(reqAddr, A_SCR64) || at(reqAddr, A_DMAAD) || at(reqAddr, A_ENAB))
        strobe.wrStage = 1'b1;
      if (at(reqAddr, A_SCR64H)) begin strobe.wrScr64   = 1'b1; strobe.commitHi = 1'b1; end
      if (at(reqAddr, A_DMAADH)) begin strobe.wrDmaAddr = 1'b1; strobe.commitHi = 1'b1; end
      if (at(reqAddr, A_ENABH))  begin strobe.wrEnable  = 1'b1; strobe.commitHi = 1'b1; end
      if (at(reqAddr, A_DMASZ))  strobe.wrDmaSize = 1'b1;
      if (at(reqAddr, A_CTRL))   strobe.doReset   = resetBit;
    end else if (reqValid && reqWrite && ok8) begin
      if (at(reqAddr, A_SCR64))  strobe.wrScr64   = 1'b1;
      if (at(reqAddr, A_DMAAD))  strobe.wrDmaAddr = 1'b1;
      if (at(reqAddr, A_ENAB))   strobe.wrEnable  = 1'b1;
    end
    if (ok4) begin
      if (at(reqAddr, A_DUMMY0) || at(reqAddr, A_DUMMY1) ||
          at(reqAddr, A_DUMMY2) || at(reqAddr, A_DUMMY3)) strobe.rdSel = SEL_DUMMY;
      if (at(reqAddr, A_SCR32))                            strobe.rdSel = SEL_SCR32;
      if (at(reqAddr, A_SCR64) || at(reqAddr, A_SCR64H))   strobe.rdSel = SEL_SCR64;
      if (at(reqAddr, A_DMAAD) || at(reqAddr, A_DMAADH))   strobe.rdSel = SEL_DMAAD;
      if (at(reqAddr, A_DMASZ))                            strobe.rdSel = SEL_DMASZ;
      if (at(reqAddr, A_COUNT))                            strobe.rdSel = SEL_COUNT;
      if (at(reqAddr, A_LINK) || at(reqAddr, A_LINKH))     strobe.rdSel = SEL_LINK;
      if (at(reqAddr, A_ENAB) || at(reqAddr, A_ENABH))     strobe.rdSel = SEL_ENAB;
      if (at(reqAddr, A_SWID) || at(reqAddr, A_SWIDH))     strobe.rdSel = SEL_SWID;
    end else if (ok8) begin
      if (at(reqAddr, A_DUMMY0) || at(reqAddr, A_DUMMY2))  strobe.rdSel = SEL_DUMMY;
      if (at(reqAddr, A_SCR64))                            strobe.rdSel = SEL_SCR64;
      if (at(reqAddr, A_DMAAD))                            strobe.rdSel = SEL_DMAAD;
      if (at(reqAddr, A_LINK))                             strobe.rdSel = SEL_LINK;
      if (at(reqAddr, A_ENAB))                             strobe.rdSel = SEL_ENAB;
      if (at(reqAddr, A_SWID))                             strobe.rdSel = SEL_SWID;
    end
  end

  // R11: an access of illegal size never raises a write strobe
  a_r11_bad_size_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && badSize) |->
      !(strobe.wrScr32 || strobe.wrScr64 || strobe.wrDmaAddr || strobe.wrDmaSize ||
        strobe.wrEnable || strobe.wrStage || strobe.doReset));

endmodule

// File: rtl/swreg_datapath.sv
module swreg_datapath
  import swreg_pkg::*;
#(
  parameter int          MAX_PORTS = 8,
  parameter int          PORTS     = 8,
  parameter logic [63:0] SWITCH_ID = 64'h0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strobe,
  input  logic [63:0]          reqWdata,
  input  logic [MAX_PORTS-1:0] linkUp,
  output logic                 rdValid,
  output logic [63:0]          rdData,
  output logic [MAX_PORTS-1:0] portEnable,
  output logic                 ctrlResetPulse
);

  localparam logic [63:0] PORT_MASK = ((64'd1 << PORTS) - 64'd1) << 1;

  logic [31:0] scr32Reg, dmaSizeReg, stageReg;
  logic [63:0] scr64Reg, dmaAddrReg, enBitmap, wrVal64, linkBitmap, selVal;

  assign wrVal64 = strobe.commitHi ? {reqWdata[31:0], stageReg} : reqWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scr32Reg       <= '0;
      scr64Reg       <= '0;
      dmaAddrReg     <= '0;
      dmaSizeReg     <= '0;
      stageReg       <= '0;
      enBitmap       <= '0;
      ctrlResetPulse <= 1'b0;
    end else begin
      ctrlResetPulse <= strobe.doReset;
      if (strobe.doReset) begin
        scr32Reg   <= '0;
        scr64Reg   <= '0;
        dmaAddrReg <= '0;
        dmaSizeReg <= '0;
        stageReg   <= '0;
        enBitmap   <= '0;
      end else begin
        if (strobe.wrScr32)   scr32Reg   <= reqWdata[31:0];
        if (strobe.wrDmaSize) dmaSizeReg <= reqWdata[31:0];
        if (strobe.wrScr64)   scr64Reg   <= wrVal64;
        if (strobe.wrDmaAddr) dmaAddrReg <= wrVal64;
        if (strobe.wrEnable)  enBitmap   <= wrVal64 & PORT_MASK;
        if (strobe.wrStage)   stageReg   <= reqWdata[31:0];
        else if (strobe.commitHi) stageReg <= '0;
      end
    end
  end

  for (genvar i = 0; i < MAX_PORTS; i++) begin : g_port
    if (i < PORTS) begin : g_live
      assign portEnable[i] = enBitmap[i+1];
    end else begin : g_dead
      assign portEnable[i] = 1'b0;
    end
  end

  assign linkBitmap = ({{(64-MAX_PORTS){1'b0}}, linkUp} << 1) & PORT_MASK;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DUMMY: selVal = DUMMY_WORD;
      SEL_SCR32: selVal = {32'd0, scr32Reg << 1};
      SEL_SCR64: selVal = scr64Reg << 1;
      SEL_DMAAD: selVal = dmaAddrReg;
      SEL_DMASZ: selVal = {32'd0, dmaSizeReg};
      SEL_COUNT: selVal = 64'(PORTS);
      SEL_LINK:  selVal = linkBitmap;
      SEL_ENAB:  selVal = enBitmap;
      SEL_SWID:  selVal = SWITCH_ID;
      default:   selVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) begin
        if (strobe.rdOnes)      rdData <= '1;
        else if (strobe.rdWide) rdData <= selVal;
        else                    rdData <= {32'd0, strobe.rdHi ? selVal[63:32] : selVal[31:0]};
      end
    end
  end

  // R3: a high-word commit always empties the staging register
  a_r3_stage_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitHi && !strobe.wrStage) |=> (stageReg == 32'd0));

  // R8: the reset pulse coincides with cleared registers and ports
  a_r8_pulse_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctrlResetPulse |-> (portEnable == '0 && scr32Reg == '0 && scr64Reg == '0 &&
                        dmaAddrReg == '0 && stageReg == '0));

  // R7: enables only move on an enable write or a control reset
  a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEnable || strobe.doReset) |=> $stable(portEnable));

  // R2: every accepted read is answered on the next cycle
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid);

endmodule

// File: rtl/swreg_bank.sv
module swreg_bank
  import swreg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_PORTS = 10,
  parameter int          MAX_PORTS = 8,
  parameter logic [63:0] SWITCH_ID = 64'h0A1B_2C3D_4E5F_6071
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [3:0]           reqSize,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [63:0]          reqWdata,
  output logic                 rdValid,
  output logic [63:0]          rdData,
  input  logic [MAX_PORTS-1:0] linkUp,
  output logic [MAX_PORTS-1:0] portEnable,
  output logic                 ctrlResetPulse
);

  localparam int PORTS = (NUM_PORTS > MAX_PORTS) ? MAX_PORTS : NUM_PORTS;

  bankStrobe_t strobe;

  swreg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqAddr  (reqAddr),
    .resetBit (reqWdata[0]),
    .strobe   (strobe)
  );

  swreg_datapath #(
    .MAX_PORTS (MAX_PORTS),
    .PORTS     (PORTS),
    .SWITCH_ID (SWITCH_ID)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqWdata       (reqWdata),
    .linkUp         (linkUp),
    .rdValid        (rdValid),
    .rdData         (rdData),
    .portEnable     (portEnable),
    .ctrlResetPulse (ctrlResetPulse)
  );

endmodule

// File: tb/swreg_bank_tb.sv
`timescale 1ns/1ps
module swreg_bank_tb;

  localparam int          PORTS = 8;
  localparam logic [63:0] SWID  = 64'h0A1B_2C3D_4E5F_6071;
  localparam logic [63:0] MASK  = ((64'd1 << PORTS) - 64'd1) << 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0]  reqSize = 4'd4;
  logic [7:0]  reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        rdValid;
  logic [63:0] rdData;
  logic [7:0]  linkUp = '0;
  logic [7:0]  portEnable;
  logic        ctrlResetPulse;

  int nChk = 0, nFail = 0;
  logic        pulseSeen, validSeen;
  logic [31:0] mScr32, mDmaSize, mStage;
  logic [63:0] mScr64, mDma, mEn;

  always #10 clk = ~clk;

  swreg_bank u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .linkUp(linkUp),
    .portEnable(portEnable), .ctrlResetPulse(ctrlResetPulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mScr32 = 0; mScr64 = 0; mDma = 0; mDmaSize = 0; mStage = 0; mEn = 0;
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    if (sz == 4) begin
      case (a)
        8'h10: mScr32 = d[31:0];
        8'h18, 8'h20, 8'h48: mStage = d[31:0];
        8'h1C: begin mScr64 = {d[31:0], mStage}; mStage = 0; end
        8'h24: begin mDma = {d[31:0], mStage}; mStage = 0; end
        8'h4C: begin mEn = {d[31:0], mStage} & MASK; mStage = 0; end
        8'h28: mDmaSize = d[31:0];
        8'h30: if (d[0]) modelReset();
        default: ;
      endcase
    end else if (sz == 8) begin
      case (a)
        8'h18: mScr64 = d;
        8'h20: mDma = d;
        8'h48: mEn = d & MASK;
        default: ;
      endcase
    end
  endtask

  function automatic logic [63:0] expRead(input logic [7:0] a, input logic [3:0] sz);
    logic [63:0] lnk, dbl;
    lnk = ({56'd0, linkUp} << 1) & MASK;
    dbl = mScr64 << 1;
    if (sz != 4 && sz != 8) return '1;
    if (sz == 8) begin
      case (a)
        8'h00, 8'h08: return 64'hDEADBABE_DEADBABE;
        8'h18: return dbl;
        8'h20: return mDma;
        8'h40: return lnk;
        8'h48: return mEn;
        8'h50: return SWID;
        default: return 0;
      endcase
    end
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return 64'hDEADBABE;
      8'h10: return {32'd0, mScr32 << 1};
      8'h18: return {32'd0, dbl[31:0]};
      8'h1C: return {32'd0, dbl[63:32]};
      8'h20: return {32'd0, mDma[31:0]};
      8'h24: return {32'd0, mDma[63:32]};
      8'h28: return {32'd0, mDmaSize};
      8'h38: return 64'(PORTS);
      8'h40: return {32'd0, lnk[31:0]};
      8'h44: return {32'd0, lnk[63:32]};
      8'h48: return {32'd0, mEn[31:0]};
      8'h4C: return {32'd0, mEn[63:32]};
      8'h50: return {32'd0, SWID[31:0]};
      8'h54: return {32'd0, SWID[63:32]};
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] expPorts();
    return mEn[8:1];
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqSize = sz; reqWdata = d;
    @(negedge clk);
    pulseSeen = ctrlResetPulse;
    reqValid = 0; reqWrite = 0;
    modelWrite(a, sz, d);
  endtask

  task automatic doRead(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] q);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a; reqSize = sz; reqWdata = '0;
    @(negedge clk);
    q = rdData; validSeen = rdValid;
    reqValid = 0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [3:0] sz);
    logic [63:0] q;
    doRead(a, sz, q);
    chk(tag, q, expRead(a, sz));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [63:0] q;
    logic [7:0] addrs [0:23];
    int seedDummy;
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18, 8'h1C, 8'h20,
              8'h24, 8'h28, 8'h30, 8'h38, 8'h40, 8'h44, 8'h48, 8'h4C,
              8'h50, 8'h54, 8'h34, 8'h60, 8'h12, 8'h1A, 8'h3C, 8'hFC};
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 portEnable", {56'd0, portEnable}, 0);
    chk("R1 rdValid", {63'd0, rdValid}, 0);
    rdChk("R1 scr64", 8'h18, 8);
    rdChk("R1 dma", 8'h20, 8);
    // R2 latency and zero upper word
    doRead(8'h04, 4, q);
    chk("R2 rdValid", {63'd0, validSeen}, 1);
    chk("R2 narrow upper zero", q, 64'h0000_0000_DEADBABE);
    // R3 shared staging across registers
    doWrite(8'h18, 4, 64'h1111_2222);
    doWrite(8'h24, 4, 64'h3333);
    rdChk("R3 cross commit dma", 8'h20, 8);
    doWrite(8'h1C, 4, 64'h5);
    rdChk("R3 stage cleared", 8'h18, 8);
    // R4 full write leaves staging alone
    doWrite(8'h48, 4, 64'hAB);
    doWrite(8'h20, 8, 64'hFEDC_BA98_7654_3210);
    doWrite(8'h1C, 4, 64'h0);
    rdChk("R4 stage kept", 8'h18, 8);
    doWrite(8'h18, 8, 64'h8000_0000_0000_0001);
    rdChk("R4 R5 scr64 doubled", 8'h18, 8);
    rdChk("R5 scr64 high half", 8'h1C, 4);
    // R5 32-bit doubling
    doWrite(8'h10, 4, 64'h8000_0003);
    rdChk("R5 scr32 doubled", 8'h10, 4);
    // R6 dummies
    rdChk("R6 dummy 0x0C", 8'h0C, 4);
    rdChk("R6 dummy wide 0x08", 8'h08, 8);
    rdChk("R6 dummy wide 0x04", 8'h04, 8);
    // R7 bitmaps
    linkUp = 8'b1000_0001;
    rdChk("R7 link bitmap", 8'h40, 8);
    doWrite(8'h48, 8, '1);
    chk("R7 portEnable all", {56'd0, portEnable}, 64'hFF);
    rdChk("R7 enable bitmap", 8'h48, 8);
    doWrite(8'h48, 8, 64'h1);
    chk("R7 bit0 dropped", {56'd0, portEnable}, 0);
    doWrite(8'h48, 8, 64'h14);
    chk("R7 ports 1,3", {56'd0, portEnable}, 64'h0A);
    // R8 control reset
    doWrite(8'h10, 4, 64'h77);
    doWrite(8'h30, 4, 64'h2);
    chk("R8 no pulse on bit0 clear", {63'd0, pulseSeen}, 0);
    rdChk("R8 bit0 clear keeps", 8'h10, 4);
    doWrite(8'h18, 4, 64'h99);
    doWrite(8'h30, 4, 64'h1);
    chk("R8 pulse", {63'd0, pulseSeen}, 1);
    chk("R8 ports off", {56'd0, portEnable}, 0);
    @(negedge clk);
    chk("R8 pulse one cycle", {63'd0, ctrlResetPulse}, 0);
    rdChk("R8 scr32 cleared", 8'h10, 4);
    rdChk("R8 dma cleared", 8'h20, 8);
    doWrite(8'h1C, 4, 64'h1);
    rdChk("R8 stage cleared", 8'h18, 8);
    // R9 count
    rdChk("R9 count capped", 8'h38, 4);
    // R10 unimplemented
    doWrite(8'h34, 4, 64'h1234);
    rdChk("R10 unimpl read", 8'h34, 4);
    doWrite(8'h10, 8, 64'h55);
    rdChk("R10 wide to narrow reg", 8'h10, 4);
    rdChk("R10 wide read narrow reg", 8'h10, 8);
    // R11 bad size
    doWrite(8'h10, 2, 64'h4444);
    rdChk("R11 bad write ignored", 8'h10, 4);
    rdChk("R11 bad read ones", 8'h10, 1);
    // R12 switch id
    doWrite(8'h50, 8, 64'h0);
    rdChk("R12 switch id", 8'h50, 8);
    rdChk("R12 switch id hi", 8'h54, 4);
    // random mix
    seedDummy = $urandom(32'd20240607);
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [3:0]  sz;
      logic [63:0] d;
      int r;
      a = addrs[$urandom % 24];
      r = $urandom % 10;
      sz = (r < 5) ? 4'd4 : (r < 9) ? 4'd8 : 4'($urandom % 3 + 1);
      d = {$urandom, $urandom};
      if (a == 8'h30) d[0] = (($urandom % 6) == 0);
      if (($urandom % 8) == 0) linkUp = 8'($urandom);
      if ($urandom % 2) begin
        doWrite(a, sz, d);
        chk("R7 R3 random portEnable", {56'd0, portEnable}, {56'd0, expPorts()});
      end else begin
        rdChk("R2 R5 R10 random read", a, sz);
      end
    end
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule